// File: doc/BRIEF.md
# Multiple Correlated Sampling Amplitude Filter

This block sits behind the ADC of one channel whose front end is a slowly leaking charge integrator with a controlled rise time. Every ADC sample enters the block with a valid strobe, and a marker flags the sample at the pulse's trigger point. The block takes up to `MAX_PAIRS` sample pairs around the marker. Each pair is a sample some number of intervals after the marker minus the sample the same number of intervals before it. The block forms a weighted sum of these differences. The weights fall off as 1/k and are normalised to sum to one, which gives the least noise variance for this front end.

A configuration input selects how many pairs are used. Using more pairs lowers the noise. With four pairs the normalised variance is 12/25, about half that of a single pair. The amplitude comes out as one rounded, signed word with a one-cycle valid strobe. A marker that cannot be served is dropped and sets a sticky error flag.

Top module: `mcsFilter`

## Requirements
- R1: After reset `ampValid` is 0, `ampOut` is 0 and `errFlag` is 0.
- R2: `pairSel` value v selects min(v+1, MAX_PAIRS) pairs. The value is latched when a marker is accepted, and later changes do not affect a computation already in progress.
- R3: Pair k (k = 1..N) is the valid sample k valid samples after the marker sample minus the valid sample k valid samples before it. The marker sample itself is in no pair. Cycles with `sampleValid` low do not advance the count.
- R4: Weight k for N pairs is round(2048 * (1/k) / (1 + 1/2 + ... + 1/N)), held as a 12-bit unsigned constant. N=1 gives 2048, N=2 gives 1365/683, N=3 gives 1117/559/372, and N=4 gives 983/492/328/246.
- R5: `ampOut` equals floor((sum of w_k * d_k + 1024) / 2048) as a signed DATA_W+2-bit value. It is presented with `ampValid` high for exactly one cycle, the cycle after the clock edge that captures the last post-marker sample. Between results, `ampOut` holds its value.
- R6: `marker` is recognised only in a cycle where `sampleValid` is high. Otherwise it has no effect.
- R7: A marker that arrives when fewer than N valid samples have been seen since reset (not counting the marker sample) is ignored and sets `errFlag`.
- R8: A marker that arrives while a computation is in progress is ignored and sets `errFlag`. This includes a marker on the sample that completes the computation. `errFlag` stays set until reset.
- R9: The history keeps filling during a computation. A marker on the first valid sample after a completion is accepted, and its pre-marker samples include the previous post-marker samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | DATA_W | Unsigned ADC sample |
| sampleValid | input | 1 | Sample strobe |
| marker | input | 1 | Trigger point on this sample |
| pairSel | input | SEL_W | Pair count minus one |
| ampOut | output | DATA_W+2 | Signed amplitude |
| ampValid | output | 1 | One-cycle result strobe |
| errFlag | output | 1 | Sticky dropped-marker flag |

## Verification
The bench builds the block with its defaults: 12-bit samples, 12-bit weights and four pairs. With these values every pair count from one to four can be selected, and the extreme steps from 0 to full scale and back reach the widest accumulator values and the largest signed outputs. Because four is the deepest history, the bench can probe a marker that has too little history for the selected count, and can show that a completed pulse's post-marker samples become the next pulse's pre-marker samples.

// File: rtl/mcsPkg.sv
package mcsPkg;

  localparam int IDX_W = 5;

  typedef struct packed {
    logic             shiftHist;
    logic             takeSnap;
    logic             accAdd;
    logic             finish;
    logic [IDX_W-1:0] pairIdx;
    logic [IDX_W-1:0] nPairs;
  } mcsStrobe_t;

  function automatic int gcdOf(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // weight of pair k out of n, scaled by 2**frac, rounded to nearest
  function automatic int weightOf(input int k, input int n, input int frac);
    int l;
    int s;
    l = 1;
    for (int j = 1; j <= n; j++) l = (l / gcdOf(l, j)) * j;
    s = 0;
    for (int j = 1; j <= n; j++) s = s + l / j;
    return (2 * (1 << frac) * (l / k) + s) / (2 * s);
  endfunction

endpackage

// File: rtl/mcsCtrl.sv
module mcsCtrl
  import mcsPkg::*;
#(
  parameter int MAX_PAIRS = 4,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             marker,
  input  logic [SEL_W-1:0] pairSel,
  output mcsStrobe_t       strobe,
  output logic             errFlag
);

  logic             busy;
  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] nReg;
  logic [IDX_W-1:0] histCnt;
  logic [IDX_W-1:0] reqN;
  logic             accept;
  logic             reject;
  logic             lastPair;

  always_comb begin
    if (int'(pairSel) + 1 > MAX_PAIRS) reqN = IDX_W'(MAX_PAIRS);
    else                               reqN = IDX_W'(pairSel) + IDX_W'(1);
  end

  assign accept   = marker && sampleValid && !busy && (histCnt >= reqN);
  assign reject   = marker && sampleValid && !accept;
  assign lastPair = busy && sampleValid && (idxReg == nReg - IDX_W'(1));

  always_comb begin
    strobe.shiftHist = sampleValid;
    strobe.takeSnap  = accept;
    strobe.accAdd    = busy && sampleValid;
    strobe.finish    = lastPair;
    strobe.pairIdx   = idxReg;
    strobe.nPairs    = nReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      idxReg  <= '0;
      nReg    <= IDX_W'(1);
      histCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      if (sampleValid && histCnt < IDX_W'(MAX_PAIRS)) histCnt <= histCnt + IDX_W'(1);
      if (reject) errFlag <= 1'b1;
      if (accept) begin
        busy   <= 1'b1;
        idxReg <= '0;
        nReg   <= reqN;
      end else if (lastPair) begin
        busy   <= 1'b0;
        idxReg <= '0;
      end else if (busy && sampleValid) begin
        idxReg <= idxReg + IDX_W'(1);
      end
    end
  end

  // R8: the error flag never clears once set
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R6: a snapshot is only taken on a valid sample that carries a marker
  p_snap_sample_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeSnap |-> (sampleValid && marker));

  // R7: an accepted marker always follows enough history
  p_hist_enough_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeSnap |=> (strobe.nPairs <= histCnt));

endmodule

// File: rtl/mcsDatapath.sv
module mcsDatapath
  import mcsPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int WGT_W     = 12,
  parameter int MAX_PAIRS = 4,
  parameter int OUT_W     = DATA_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       sampleIn,
  input  mcsStrobe_t              strobe,
  output logic signed [OUT_W-1:0] ampOut,
  output logic                    ampValid
);

  localparam int FRAC   = WGT_W - 1;
  localparam int ACC_W  = OUT_W + FRAC;
  localparam int PROD_W = DATA_W + WGT_W + 2;
  localparam logic signed [ACC_W-1:0] ROUND_K =
    {{(ACC_W - FRAC){1'b0}}, 1'b1, {(FRAC - 1){1'b0}}};

  logic [DATA_W-1:0] hist [MAX_PAIRS];
  logic [DATA_W-1:0] snap [MAX_PAIRS];
  logic [WGT_W-1:0]  wTab [MAX_PAIRS][MAX_PAIRS];

  // wTab[n-1][k-1] : weight of pair k when n pairs are used
  for (genvar gn = 0; gn < MAX_PAIRS; gn++) begin : gRow
    for (genvar gk = 0; gk < MAX_PAIRS; gk++) begin : gCol
      if (gk <= gn) begin : gUsed
        assign wTab[gn][gk] = WGT_W'(weightOf(gk + 1, gn + 1, FRAC));
      end else begin : gZero
        assign wTab[gn][gk] = '0;
      end
    end
  end

  logic [DATA_W-1:0]        preSel;
  logic [WGT_W-1:0]         wSel;
  logic signed [DATA_W:0]   diffS;
  logic signed [WGT_W:0]    wS;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  sumNow;
  logic signed [ACC_W-1:0]  sumRnd;

  always_comb begin
    preSel = '0;
    wSel   = '0;
    for (int i = 0; i < MAX_PAIRS; i++) begin
      if (strobe.pairIdx == IDX_W'(i)) preSel = snap[i];
      for (int n = 0; n < MAX_PAIRS; n++) begin
        if (strobe.pairIdx == IDX_W'(i) && strobe.nPairs == IDX_W'(n + 1))
          wSel = wTab[n][i];
      end
    end
  end

  assign diffS  = $signed({1'b0, sampleIn}) - $signed({1'b0, preSel});
  assign wS     = $signed({1'b0, wSel});
  assign prod   = diffS * wS;
  assign sumNow = acc + ACC_W'(prod);
  assign sumRnd = sumNow + ROUND_K;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_PAIRS; i++) begin
        hist[i] <= '0;
        snap[i] <= '0;
      end
      acc      <= '0;
      ampOut   <= '0;
      ampValid <= 1'b0;
    end else begin
      ampValid <= 1'b0;
      if (strobe.shiftHist) begin
        hist[0] <= sampleIn;
        for (int i = 1; i < MAX_PAIRS; i++) hist[i] <= hist[i-1];
      end
      if (strobe.takeSnap) begin
        for (int i = 0; i < MAX_PAIRS; i++) snap[i] <= hist[i];
        acc <= '0;
      end else if (strobe.accAdd) begin
        if (strobe.finish) begin
          ampOut   <= sumRnd[ACC_W-1:FRAC];
          ampValid <= 1'b1;
          acc      <= '0;
        end else begin
          acc <= sumNow;
        end
      end
    end
  end

  // R5: result strobe lasts one cycle
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    ampValid |=> !ampValid);

  // R5: amplitude holds between results
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ampValid |-> $stable(ampOut));

  // R3: accumulation never reaches beyond the selected pair count
  p_idx_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accAdd |-> (strobe.pairIdx < strobe.nPairs));

  // R5: a result follows the final pair in the next cycle
  p_finish_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accAdd && strobe.finish) |=> ampValid);

endmodule

// File: rtl/mcsFilter.sv
module mcsFilter
  import mcsPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int WGT_W     = 12,
  parameter int MAX_PAIRS = 4,
  localparam int SEL_W    = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
  localparam int OUT_W    = DATA_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       sampleIn,
  input  logic                    sampleValid,
  input  logic                    marker,
  input  logic [SEL_W-1:0]        pairSel,
  output logic signed [OUT_W-1:0] ampOut,
  output logic                    ampValid,
  output logic                    errFlag
);

  mcsStrobe_t strobe;

  mcsCtrl #(
    .MAX_PAIRS(MAX_PAIRS),
    .SEL_W    (SEL_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .marker     (marker),
    .pairSel    (pairSel),
    .strobe     (strobe),
    .errFlag    (errFlag)
  );

  mcsDatapath #(
    .DATA_W   (DATA_W),
    .WGT_W    (WGT_W),
    .MAX_PAIRS(MAX_PAIRS),
    .OUT_W    (OUT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .sampleIn(sampleIn),
    .strobe  (strobe),
    .ampOut  (ampOut),
    .ampValid(ampValid)
  );

endmodule

// File: tb/tb_mcsFilter.sv
module tb_mcsFilter;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int MAXP = 4;
  localparam int WATCHDOG = 20000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [DW-1:0]       sampleIn = '0;
  logic                sampleValid = 1'b0;
  logic                marker = 1'b0;
  logic [1:0]          pairSel = '0;
  logic signed [DW+1:0] ampOut;
  logic                ampValid;
  logic                errFlag;

  mcsFilter dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .marker(marker), .pairSel(pairSel), .ampOut(ampOut), .ampValid(ampValid),
    .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference
  int  hist[$];
  int  pre[MAXP];
  int  diffs[$];
  bit  mBusy = 0;
  int  mN = 1;
  bit  expValid = 0;
  int  expOut = 0;
  bit  expErr = 0;

  function automatic int refWeight(input int k, input int n);
    real h;
    h = 0.0;
    for (int j = 1; j <= n; j++) h = h + 1.0 / j;
    return int'(2048.0 / (k * h));
  endfunction

  always @(posedge clk) begin
    cycles++;
    expValid = 0;
    if (!rstN) begin
      hist.delete(); diffs.delete();
      mBusy = 0; expOut = 0; expErr = 0;
    end else if (sampleValid) begin
      bit wasBusy;
      int n;
      wasBusy = mBusy;
      if (mBusy) begin
        diffs.push_back(int'(sampleIn) - pre[diffs.size()]);
        if (diffs.size() == mN) begin
          int s;
          s = 0;
          for (int k = 1; k <= mN; k++) s += refWeight(k, mN) * diffs[k-1];
          expOut = (s + 1024) >>> 11;
          expValid = 1;
          mBusy = 0;
        end
      end
      n = (int'(pairSel) + 1 > MAXP) ? MAXP : int'(pairSel) + 1;
      if (marker) begin
        if (!wasBusy && hist.size() >= n) begin
          for (int k = 0; k < n; k++) pre[k] = hist[hist.size()-1-k];
          mN = n; mBusy = 1; diffs.delete();
        end else begin
          expErr = 1;
        end
      end
      hist.push_back(int'(sampleIn));
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    checks++;
    if (ampValid !== expValid || errFlag !== expErr || int'(ampOut) != expOut) begin
      fails++;
      $display("FAIL %s: valid/err/out actual %0b/%0b/%0d expected %0b/%0b/%0d",
               curReq, ampValid, errFlag, ampOut, expValid, expErr, expOut);
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic push(input int v, input bit mk);
    @(negedge clk);
    sampleIn = DW'(v); sampleValid = 1'b1; marker = mk;
    @(posedge clk);
  endtask

  task automatic gap(input bit mk);
    @(negedge clk);
    sampleValid = 1'b0; marker = mk; sampleIn = DW'($urandom);
    @(posedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; marker = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one pulse: baseline b, step s, n pairs
  task automatic pulse(input int b, input int s, input int sel);
    pairSel = 2'(sel);
    for (int i = 0; i < 4; i++) push(b + i, 0);
    push(b + 3, 1);
    for (int i = 0; i < 6; i++) push(b + s + i * 2, 0);
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    curReq = "R7";
    pairSel = 2'd3;
    push(10, 0); push(11, 0); push(12, 1);
    push(13, 0); push(14, 0);

    curReq = "R1";
    doReset();
    repeat (2) @(posedge clk);

    curReq = "R4";
    for (int sel = 0; sel < 4; sel++) pulse(100 + sel * 50, 1000, sel);

    curReq = "R3";
    pairSel = 2'd3;
    for (int i = 0; i < 4; i++) push(200 + 7 * i, 0);
    push(230, 1);
    gap(0); push(900, 0); gap(0); gap(0); push(950, 0);
    curReq = "R6";
    gap(1); push(1010, 0); gap(1); push(1100, 0);
    push(1110, 0); push(1120, 0);

    curReq = "R2";
    pairSel = 2'd1;
    push(300, 0); push(305, 1);
    pairSel = 2'd3;
    push(800, 0); push(820, 0); push(830, 0);

    curReq = "R5";
    pairSel = 2'd3;
    for (int i = 0; i < 4; i++) push(0, 0);
    push(0, 1);
    for (int i = 0; i < 4; i++) push(4095, 0);
    for (int i = 0; i < 4; i++) push(4095, 0);
    push(4095, 1);
    for (int i = 0; i < 4; i++) push(0, 0);
    pairSel = 2'd2;
    push(1, 0); push(2, 1); push(3, 0); push(2, 0); push(5, 0);

    curReq = "R9";
    pairSel = 2'd1;
    push(400, 0); push(401, 0); push(402, 1); push(700, 0); push(710, 0);
    push(720, 1); push(990, 0); push(995, 0); push(996, 0);

    curReq = "R5";
    for (int r = 0; r < 30; r++) begin
      pairSel = 2'($urandom_range(0, 3));
      for (int i = 0; i < 4; i++) push($urandom_range(0, 4095), 0);
      push($urandom_range(0, 4095), 1);
      for (int i = 0; i < 5; i++) begin
        if ($urandom_range(0, 3) == 0) gap(0);
        push($urandom_range(0, 4095), 0);
      end
    end

    curReq = "R8";
    pairSel = 2'd3;
    for (int i = 0; i < 4; i++) push(50, 0);
    push(50, 1);
    push(600, 0); push(610, 1); push(620, 0); push(630, 1);
    push(640, 0); push(650, 0);
    repeat (3) @(posedge clk);

    @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule